// File: doc/BRIEF.md
# Prescaled Tick Timer

A periodic down-counting timer that software programs through a small write bus of four 32-bit registers: control, count, period and scale. A prescaler divides the clock by scale plus one. Each prescaled tick lowers the count by one. When the count runs out, a sticky interrupt flag is raised. The count is then either refilled from the period register or left at zero. All four registers can be read back at any time through a combinational read port, and the flag also drives the `irq` output.

Control bits: bit 0 powers the timer, bit 1 enables counting, bit 2 selects auto-reload, and bit 3 is the interrupt flag. The timer runs only while both the power and enable bits are set. Register word addresses are 0 for control, 1 for count, 2 for period and 3 for scale.

A three-state machine governs counting:
- `ST_OFF` means the timer is not running.
- `ST_RUN` means it is counting.
- `ST_DONE` means it is running but has stopped at zero because auto-reload is off.

Its transitions are:
- *start*: OFF to RUN or DONE, when power and enable both become set.
- *halt*: any state to OFF, when either bit is cleared.
- *expire-stop*: RUN to DONE, when the count empties with reload off.
- *rearm*: DONE to RUN, when a nonzero count or period is written, or when reload is turned on.

Top module: `tick_timer`

## Requirements
- R1: After reset, all four registers read zero, `irq` is low and the timer is idle.
- R2: A period write stores the value and also loads it into the count, whether or not the timer is running.
- R3: A count write takes effect immediately, even while the timer is running.
- R4: While running with scale S, a tick occurs every S+1 clocks, counted from the enable write, and each tick lowers the count by one.
- R5: Disabling the timer holds the current count. Re-enabling resumes from that count with a fresh divider. A control write that leaves the run state unchanged does not disturb the divider or the count.
- R6: A scale write while running leaves the count unchanged and restarts the divider. The next tick then comes S+1 clocks after the write, using the new S.
- R7: A tick on a count of one or zero sets the flag (control bit 3) and `irq`. The flag stays set until a control write puts a 0 in bit 3. A control write with bit 3 equal to 1 sets the flag.
- R8: With auto-reload (control bit 2) set, expiry refills the count from the period register.
- R9: With auto-reload clear, expiry leaves the count at zero, and it does not change again until it is written.
- R10: The timer counts only when both power (bit 0) and enable (bit 1) are set. Either bit alone holds the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt flag level |

## Verification
The assertions assume one write per cycle to a single address. They also assume the write bus is never driven X while `wr_en` is high. The stop and reload properties assume that no count or period write lands in the same cycle as an expiry, because the write would take priority. The stimulus applies each write for exactly one clock, starting from a falling edge. Expiry-related writes are scheduled on cycles where the computed tick schedule shows no tick.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tt_state_e;

    localparam int REG_AW = 2;
    localparam logic [REG_AW-1:0] A_CTRL   = 2'd0;
    localparam logic [REG_AW-1:0] A_COUNT  = 2'd1;
    localparam logic [REG_AW-1:0] A_PERIOD = 2'd2;
    localparam logic [REG_AW-1:0] A_SCALE  = 2'd3;

    localparam int B_PWR  = 0;
    localparam int B_EN   = 1;
    localparam int B_RLD  = 2;
    localparam int B_FLAG = 3;
    localparam int CTRL_W = 4;
endpackage

// File: rtl/tt_regs.sv
`timescale 1ns/1ps
module tt_regs
    import tick_timer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                expire,
    output logic                pwr_q,
    output logic                en_q,
    output logic                rld_q,
    output logic                flag_q,
    output logic                run_d,
    output logic                rld_d,
    output logic [DATA_W-1:0]   period_q,
    output logic [SCALE_W-1:0]  scale_q,
    output logic                scale_wr,
    output logic                cnt_wr,
    output logic                per_wr
);
    logic ctrl_wr;
    logic pwr_d, en_d, flag_d;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        cnt_wr   = wr_en && (wr_addr == A_COUNT);
        per_wr   = wr_en && (wr_addr == A_PERIOD);
        scale_wr = wr_en && (wr_addr == A_SCALE);
        pwr_d    = ctrl_wr ? wr_data[B_PWR] : pwr_q;
        en_d     = ctrl_wr ? wr_data[B_EN]  : en_q;
        rld_d    = ctrl_wr ? wr_data[B_RLD] : rld_q;
        // expiry outranks a same-cycle clearing write: the flag is sticky
        flag_d   = (ctrl_wr ? wr_data[B_FLAG] : flag_q) | expire;
        run_d    = pwr_d & en_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_q  <= 1'b0;
            en_q   <= 1'b0;
            rld_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            pwr_q  <= pwr_d;
            en_q   <= en_d;
            rld_q  <= rld_d;
            flag_q <= flag_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= '0;
            scale_q  <= '0;
        end else begin
            if (per_wr)   period_q <= wr_data;
            if (scale_wr) scale_q  <= wr_data[SCALE_W-1:0];
        end
    end

    // R7: an expiry always leaves the flag set
    a_r7_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_q);
    // R7: only a control write can drop the flag
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && wr_addr == A_CTRL)) |=> flag_q);
endmodule

// File: rtl/tt_prescaler.sv
`timescale 1ns/1ps
module tt_prescaler #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    logic [SCALE_W-1:0] div_q;

    assign tick = run && !restart && (div_q == scale);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 div_q <= '0;
        else if (!run || restart)   div_q <= '0;
        else if (div_q == scale)    div_q <= '0;
        else                        div_q <= div_q + SCALE_W'(1);
    end

    // R4: the divider never passes the programmed scale
    a_r4_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= scale);
    // R4: with scale above zero ticks never come back to back
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && scale != '0) |=> !tick);
    // R6: a scale write yields no tick on the following cycle unless scale is zero
    a_r6_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && run) |=> (!tick || scale == '0));
endmodule

// File: rtl/tt_count_fsm.sv
`timescale 1ns/1ps
module tt_count_fsm
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic              per_wr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  period_q,
    input  logic              rld_q,
    input  logic              run_d,
    input  logic              rld_d,
    output logic [CNT_W-1:0]  count_q,
    output tt_state_e         state_q,
    output logic              expire
);
    logic [CNT_W-1:0] count_d;
    tt_state_e        state_d;

    assign expire = tick && (count_q <= CNT_W'(1));

    always_comb begin
        if (per_wr)       count_d = wr_data;
        else if (cnt_wr)  count_d = wr_data;
        else if (expire)  count_d = rld_q ? period_q : '0;
        else if (tick)    count_d = count_q - CNT_W'(1);
        else              count_d = count_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                // start
                if (run_d) state_d = (count_d == '0 && !rld_d) ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (!run_d)                          state_d = ST_OFF;   // halt
                else if (count_d == '0 && !rld_d)    state_d = ST_DONE;  // expire-stop
            end
            ST_DONE: begin
                if (!run_d)                          state_d = ST_OFF;   // halt
                else if (count_d != '0 || rld_d)     state_d = ST_RUN;   // rearm
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R5 / R10: an idle timer keeps its count unless software writes it
    a_r5_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !cnt_wr && !per_wr) |=> (count_q == $past(count_q)));
    // R9: expiry without reload parks at zero
    a_r9_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !rld_q && !cnt_wr && !per_wr) |=> (count_q == '0 && state_q != ST_RUN));
    // R8: expiry with reload refills from period
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && rld_q && !cnt_wr && !per_wr) |=> (count_q == $past(period_q)));
    // R2: a period write lands in the count
    a_r2_period_load: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |=> (count_q == period_q));
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SCALE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [31:0]       rd_data,
    output logic              irq
);
    localparam int CTRL_PAD = DATA_W - CTRL_W;

    logic pwr_q, en_q, rld_q, flag_q, run_d, rld_d;
    logic scale_wr, cnt_wr, per_wr, tick, expire;
    logic [DATA_W-1:0]  period_q, count_q;
    logic [SCALE_W-1:0] scale_q;
    tt_state_e          state_q;

    tt_regs #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .expire(expire),
        .pwr_q(pwr_q), .en_q(en_q), .rld_q(rld_q), .flag_q(flag_q),
        .run_d(run_d), .rld_d(rld_d), .period_q(period_q), .scale_q(scale_q),
        .scale_wr(scale_wr), .cnt_wr(cnt_wr), .per_wr(per_wr)
    );

    tt_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN),
        .restart(scale_wr), .scale(scale_q), .tick(tick)
    );

    tt_count_fsm #(.CNT_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .per_wr(per_wr),
        .wr_data(wr_data), .period_q(period_q), .rld_q(rld_q),
        .run_d(run_d), .rld_d(rld_d), .count_q(count_q), .state_q(state_q),
        .expire(expire)
    );

    always_comb begin
        unique case (rd_addr)
            A_CTRL:   rd_data = {{CTRL_PAD{1'b0}}, flag_q, rld_q, en_q, pwr_q};
            A_COUNT:  rd_data = count_q;
            A_PERIOD: rd_data = period_q;
            default:  rd_data = DATA_W'(scale_q);
        endcase
    end

    assign irq = flag_q;

    // R10: running implies both power and enable are set
    a_r10_run_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |-> (pwr_q && en_q));
    // R1: state is one-hot-or-idle legal after reset
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_OFF, ST_RUN, ST_DONE});
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        int          sel;   // 0..3 register, 4 = irq pin
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    tick_timer u_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    // monitor: pops expected items and compares against the design
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            if (it.sel == 4) begin
                #0.1;
                got = {31'b0, irq};
            end else begin
                rd_addr = it.sel[1:0];
                #0.1;
                got = rd_data;
            end
            n_run++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.tag, it.sel, got, it.exp);
            end
        end
    end

    task automatic expect_val(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        #0.3;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4ms;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_val(0, 0, "R1 ctrl");
        expect_val(1, 0, "R1 count");
        expect_val(2, 0, "R1 period");
        expect_val(3, 0, "R1 scale");
        expect_val(4, 0, "R1 irq");

        wr(3, 3);
        wr(2, 10);
        expect_val(2, 10, "R2 period stored");
        expect_val(1, 10, "R2 count loaded");

        wr(0, 32'h1);          // power only
        idle(8);
        expect_val(1, 10, "R10 power alone holds");
        wr(0, 32'h2);          // enable only
        idle(8);
        expect_val(1, 10, "R10 enable alone holds");

        wr(0, 32'h3);          // start, scale 3: ticks every 4 clocks
        expect_val(1, 10, "R4 no tick at start");
        idle(4);
        expect_val(1, 9, "R4 first tick");
        idle(3);
        expect_val(1, 9, "R4 between ticks");
        idle(1);
        expect_val(1, 8, "R4 second tick");

        wr(0, 32'h3);          // unchanged rewrite
        expect_val(1, 8, "R5 rewrite no disturb");
        idle(3);
        expect_val(1, 7, "R5 rewrite keeps phase");

        wr(0, 32'h1);          // disable
        idle(10);
        expect_val(1, 7, "R5 disabled holds");
        wr(0, 32'h3);
        idle(4);
        expect_val(1, 6, "R5 resume from held");

        idle(2);
        wr(3, 1);              // scale change while running
        expect_val(1, 6, "R6 count kept");
        expect_val(3, 1, "R6 scale stored");
        idle(2);
        expect_val(1, 5, "R6 new rate tick1");
        idle(2);
        expect_val(1, 4, "R6 new rate tick2");

        wr(1, 2);              // count write while running
        expect_val(1, 2, "R3 count write");
        idle(1);
        expect_val(1, 1, "R3 counts on");
        expect_val(4, 0, "R7 no flag yet");
        idle(2);
        expect_val(1, 0, "R9 stopped at zero");
        expect_val(4, 1, "R7 irq on expiry");
        expect_val(0, 32'hB, "R7 flag bit3");
        idle(6);
        expect_val(1, 0, "R9 stays zero");
        expect_val(4, 1, "R7 flag sticky");

        wr(0, 32'h7);          // clear flag, turn on reload
        expect_val(4, 0, "R7 cleared by write");
        idle(2);
        expect_val(1, 10, "R8 reload from zero");
        expect_val(4, 1, "R8 flag on reload");

        wr(0, 32'h5);          // stop, clear flag
        wr(2, 3);
        expect_val(1, 3, "R2 period reloads count");
        wr(3, 0);
        wr(0, 32'h7);
        expect_val(4, 0, "R7 still clear");
        idle(3);
        expect_val(1, 3, "R8 reload on expiry");
        expect_val(4, 1, "R8 flag set");
        idle(1);
        expect_val(1, 2, "R8 counts after reload");

        wr(0, 32'h1);
        wr(0, 32'h9);          // writing 1 to flag sets it
        expect_val(4, 1, "R7 write one sets");
        wr(0, 32'h1);
        expect_val(4, 0, "R7 write zero clears");

        wait (sb_q.size() == 0);
        #1;
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule